// File: doc/BRIEF.md
# Double-Buffered Channel Attenuation Bank

This block keeps the digital attenuation codes for six audio channels, organised as three left/right pairs. Control writes arrive on a small valid/ready write port carrying a 4-bit register address and a 9-bit word. The low eight bits of the word are an attenuation code, where 8'hFF means 0 dB. Bit 8 is a one-shot commit request. Each channel owns two registers. A staging register takes writes. An active register drives the output. A commit copies every staged code into its active register at the same moment, so several channels change gain on the same audio sample.

A commit never acts at the instant of the write. It waits for the next pulse on `sample_strobe`, which marks an input sample boundary. A broadcast address loads one code into every staging register at once. The write port never applies back-pressure: `wr_ready` is held high, and a write completes in any cycle where `wr_valid` is high. The address decoder that feeds this port and the gain arithmetic that consumes the active codes sit outside this block.

Top module: `atten_dbuf_bank`

## Requirements
- R1: After reset, every staging and active register holds 8'hFF, so all six output codes read 8'hFF.
- R2: Channel addresses are 0 (L0), 1 (R0), 4 (L1), 5 (R1), 6 (L2) and 7 (R2). They map to output slices 0 to 5 of `atten_out`, with slice i at bits [8i+7:8i]. A write with bit 8 clear changes only the addressed staging register, and no output changes, even across sample strobes.
- R3: A write with bit 8 set stores its code and arms a commit. On the next cycle with `sample_strobe` high, all six active registers load their staged codes. No output changes before that strobe.
- R4: The commit flag is not stored. A later write with bit 8 clear, followed by strobes, does not commit anything.
- R5: A write to address 8 (broadcast) loads its code into all six staging registers and replaces any earlier per-channel staged codes.
- R6: A broadcast write with bit 8 set also arms a commit of all channels.
- R7: Writes to addresses 2, 3 and 9 to 15 are ignored entirely, including their commit flag.
- R8: If a write with bit 8 set coincides with a `sample_strobe` cycle, the commit takes effect at that same clock edge. The code carried by that write is the one made active.
- R9: Active codes change only at the clock edge of a cycle in which `sample_strobe` is high and a commit is armed or arriving.
- R10: `wr_ready` is always high. Writes on consecutive cycles are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted; always high |
| wr_addr | input | 4 | Register address |
| wr_data | input | 9 | Bits 7:0 attenuation code, bit 8 commit request |
| sample_strobe | input | 1 | One-cycle pulse at each input sample boundary |
| atten_out | output | 48 | Six active codes, slice i at bits [8i+7:8i] |

## Verification
On every cycle, the assertions check the following. An active register holds still unless a commit is applied. A staging register holds still unless it is written. An armed commit survives until a strobe. A write without the commit bit never arms one. A channel write selects at most one channel, and a broadcast selects all of them. Only the bench scenarios can show the values that actually become active. These include the timing of a commit relative to the strobe, the overwrite order between broadcast and per-channel writes, and the fact that writes to the unused addresses leave the outputs untouched.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ADDR_W = 4;
  localparam int NCH    = 6;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = 4'b1000;

  // Channel i: pair i/2, side i%2 (0 = left). Pair 0 at 0..1, pairs 1,2 at 4..7.
  function automatic logic [ADDR_W-1:0] chan_addr(input int idx);
    int pair;
    int side;
    pair = idx / 2;
    side = idx % 2;
    if (pair == 0) return ADDR_W'(side);
    else           return ADDR_W'(4 + 2 * (pair - 1) + side);
  endfunction
endpackage

// File: rtl/atten_wr_decode.sv
module atten_wr_decode
  import atten_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W:0]   wr_data,
  output logic [NCH-1:0]    ch_we,
  output logic [CODE_W-1:0] code,
  output logic              commit
);
  logic           bcast;
  logic [NCH-1:0] hit;

  assign bcast = (wr_addr == BCAST_ADDR);
  assign code  = wr_data[CODE_W-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] MY_ADDR = chan_addr(i);
    assign hit[i]   = (wr_addr == MY_ADDR);
    assign ch_we[i] = wr_fire && (bcast || hit[i]);
  end

  assign commit = wr_fire && wr_data[CODE_W] && (bcast || (|hit));

  // A channel write addresses at most one channel
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !bcast) |-> $onehot0(ch_we));

  // Broadcast reaches every channel
  p_bcast_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == BCAST_ADDR) |-> (&ch_we));

  // Unused addresses produce neither enable nor commit
  p_unused_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ch_we == '0) |-> !commit);
endmodule

// File: rtl/atten_commit_ctrl.sv
module atten_commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic sample_strobe,
  output logic apply
);
  logic pending_q;

  assign apply = sample_strobe && (pending_q || commit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= (pending_q || commit) && !sample_strobe;
  end

  // An armed commit waits for a strobe
  p_pending_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !sample_strobe) |=> pending_q);

  // No commit bit, nothing armed
  p_no_stored_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !commit) |=> !pending_q);

  // A strobe always consumes the pending request
  p_strobe_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !pending_q);
endmodule

// File: rtl/atten_chan_latch.sv
module atten_chan_latch #(
  parameter int          CODE_W    = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] code,
  input  logic              apply,
  output logic [CODE_W-1:0] active
);
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] active_q;
  logic [CODE_W-1:0] stage_d;

  // Same-cycle write is forwarded so a coincident commit sees it
  assign stage_d = we ? code : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= RESET_CODE;
      active_q <= RESET_CODE;
    end else begin
      stage_q <= stage_d;
      if (apply) active_q <= stage_d;
    end
  end

  assign active = active_q;

  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(active_q));

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(stage_q));

  p_apply_matches_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (active_q == stage_q));
endmodule

// File: rtl/atten_dbuf_bank.sv
module atten_dbuf_bank
  import atten_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CODE_W:0]         wr_data,
  input  logic                    sample_strobe,
  output logic [NCH*CODE_W-1:0]   atten_out
);
  localparam logic [CODE_W-1:0] RST_CODE = '1;

  logic              wr_fire;
  logic [NCH-1:0]    ch_we;
  logic [CODE_W-1:0] code;
  logic              commit;
  logic              apply;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  atten_wr_decode #(.CODE_W(CODE_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ch_we   (ch_we),
    .code    (code),
    .commit  (commit)
  );

  atten_commit_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .sample_strobe (sample_strobe),
    .apply         (apply)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    atten_chan_latch #(.CODE_W(CODE_W), .RESET_CODE(RST_CODE)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ch_we[i]),
      .code   (code),
      .apply  (apply),
      .active (atten_out[i*CODE_W +: CODE_W])
    );
  end

  // Outputs move only on strobe cycles
  p_out_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(atten_out));
endmodule

// File: tb/tb_atten_dbuf_bank.sv
module tb_atten_dbuf_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic        sample_strobe = 1'b0;
  logic [47:0] atten_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] stage_m [6];
  logic [7:0] act_m   [6];
  bit         pend_m;

  always #2.5 clk = ~clk;

  atten_dbuf_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample_strobe(sample_strobe),
    .atten_out(atten_out)
  );

  function automatic int addr_to_ch(input logic [3:0] a);
    case (a)
      4'd0: return 0;  4'd1: return 1;  4'd4: return 2;
      4'd5: return 3;  4'd6: return 4;  4'd7: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input int ch, input logic [7:0] exp);
    logic [7:0] got;
    got = atten_out[ch*8 +: 8];
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ch%0d got %02h expected %02h", req, ch, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < 6; c++) chk(req, c, act_m[c]);
  endtask

  // Drives one cycle starting at a negedge, updates the model, checks at next negedge
  task automatic step(input bit v, input logic [3:0] a, input logic [7:0] code,
                      input bit cm, input bit strb, input string req);
    int  ch;
    bit  cmt;
    wr_valid = v; wr_addr = a; wr_data = {cm, code}; sample_strobe = strb;
    @(posedge clk);
    ch  = addr_to_ch(a);
    cmt = 1'b0;
    if (v) begin
      if (a == 4'd8) begin
        for (int c = 0; c < 6; c++) stage_m[c] = code;
        cmt = cm;
      end else if (ch >= 0) begin
        stage_m[ch] = code;
        cmt = cm;
      end
    end
    if (strb && (pend_m || cmt))
      for (int c = 0; c < 6; c++) act_m[c] = stage_m[c];
    pend_m = (pend_m || cmt) && !strb;
    @(negedge clk);
    wr_valid = 1'b0; sample_strobe = 1'b0;
    chk_all(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int c = 0; c < 6; c++) begin stage_m[c] = 8'hFF; act_m[c] = 8'hFF; end
    pend_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int c = 0; c < 6; c++) chk("R1", c, 8'hFF);

    // R2: staging-only writes to every channel, then strobes
    step(1, 4'd0, 8'h10, 0, 0, "R2");
    step(1, 4'd1, 8'h11, 0, 0, "R2");
    step(1, 4'd4, 8'h12, 0, 1, "R2");
    step(1, 4'd5, 8'h13, 0, 0, "R2");
    step(1, 4'd6, 8'h14, 0, 0, "R2");
    step(1, 4'd7, 8'h15, 0, 1, "R2");
    step(0, 4'd0, 8'h00, 0, 1, "R2");
    for (int c = 0; c < 6; c++) chk("R2", c, 8'hFF);

    // R3: commit waits for strobe, then all channels move together
    step(1, 4'd1, 8'h40, 1, 0, "R3");
    for (int c = 0; c < 6; c++) chk("R3", c, 8'hFF);
    step(0, 4'd0, 8'h00, 0, 0, "R3");
    chk("R3", 1, 8'hFF);
    step(0, 4'd0, 8'h00, 0, 1, "R3");
    chk("R3", 0, 8'h10); chk("R3", 1, 8'h40); chk("R3", 2, 8'h12);
    chk("R3", 3, 8'h13); chk("R3", 4, 8'h14); chk("R3", 5, 8'h15);

    // R4: flag not stored
    step(1, 4'd0, 8'h21, 0, 0, "R4");
    step(0, 4'd0, 8'h00, 0, 1, "R4");
    step(0, 4'd0, 8'h00, 0, 1, "R4");
    chk("R4", 0, 8'h10);

    // R5 / R8: broadcast overwrite, per-channel tweak, commit on strobe cycle
    step(1, 4'd8, 8'h22, 0, 0, "R5");
    chk("R5", 0, 8'h10);
    step(1, 4'd4, 8'h33, 0, 0, "R5");
    step(1, 4'd5, 8'h55, 1, 1, "R8");
    chk("R5", 0, 8'h22); chk("R5", 1, 8'h22); chk("R5", 2, 8'h33);
    chk("R8", 3, 8'h55); chk("R5", 4, 8'h22); chk("R5", 5, 8'h22);

    // R6: broadcast with commit
    step(1, 4'd8, 8'h77, 1, 0, "R6");
    chk("R6", 0, 8'h22);
    step(0, 4'd0, 8'h00, 0, 1, "R6");
    for (int c = 0; c < 6; c++) chk("R6", c, 8'h77);

    // R7: unused addresses ignored, including commit flag
    step(1, 4'd0, 8'h01, 0, 0, "R7");
    for (int a = 0; a < 16; a++) begin
      if (addr_to_ch(4'(a)) < 0 && a != 8) step(1, 4'(a), 8'h00, 1, 1, "R7");
    end
    for (int c = 0; c < 6; c++) chk("R7", c, 8'h77);

    // R9: sweep all addresses, both flag values, strobe phases
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 16; a++)
        for (int cm = 0; cm < 2; cm++)
          step(1, 4'(a), 8'(a * 16 + cm * 3 + s * 7 + 5), cm[0], ((a + cm + s) % 3) == 0, "R9");

    // R10: back-to-back writes always accepted
    checks++;
    if (wr_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 wr_ready got %b expected 1", wr_ready);
    end
    step(1, 4'd0, 8'hA0, 0, 0, "R10");
    step(1, 4'd1, 8'hA1, 0, 0, "R10");
    step(1, 4'd6, 8'hA2, 1, 0, "R10");
    step(1, 4'd7, 8'hA3, 0, 1, "R10");
    chk("R10", 0, 8'hA0); chk("R10", 1, 8'hA1);
    chk("R10", 4, 8'hA2); chk("R10", 5, 8'hA3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule